// File: doc/BRIEF.md
# Late-Write Zero-Turnaround SRAM Pipeline

This block is a synchronous single-port word memory with byte lanes. It is built so that a shared data bus can carry any mix of reads and writes on consecutive clocks with no idle cycle between them. A cycle is started by a load strobe. On that edge the block registers the address, the cycle type and the byte-lane write enables. A read is flow-through: the addressed word is driven during the clock period that follows the edge on which its address was registered. A write is late: its data is presented one active edge after its address.

Captured write data waits in a one-entry write registry. It is committed to the array when the next write's data arrives. A coherency path merges the registry into any read of the same word, lane by lane, so a read always returns the latest write. A continue cycle repeats the previous cycle type at the next address of a four-beat wrapping burst, in either linear or interleaved order. An active-low clock enable freezes the whole pipeline. Three chip selects and an asynchronous output enable gate the read bus.

Top module: `lwz_sram`

## Requirements
- R1: After reset the read bus is not driven (`rd_en` = 0, `rd_data` = 0) and no write is pending.
- R2: A read loaded at edge N, with all selects asserted and `out_en_n` low, gives `rd_en` = 1 and `rd_data` equal to the addressed word during the period between edge N and edge N+1.
- R3: A write takes its address and lane enables at edge N and its data at the next active edge. The read bus stays undriven during the cycle after edge N, and later reads of that address return the data.
- R4: Lane i is bits [8i+7:8i] of the data. It is written only when `lane_we_n[i]` = 0 at the write's load edge; lanes with `lane_we_n[i]` = 1 keep their old contents.
- R5: A load counts only when `sel0_n` = 0, `sel1` = 1 and `sel2_n` = 0. Any other combination makes it a deselect cycle, which writes nothing and leaves `rd_en` = 0 and `rd_data` = 0.
- R6: Writes and reads alternate on consecutive edges with no idle cycle, and every read returns the latest data.
- R7: A read of an address whose write data is still in the registry, including a read loaded on the very edge that captures that data, returns the registry lanes merged over the stored word.
- R8: While `clk_en_n` = 1, no edge changes state. `rd_data` holds, and a pending write's data is taken at the next edge with `clk_en_n` = 0.
- R9: With `load_n` = 1 and `ilv_mode` = 0, the previous cycle type repeats at an address whose upper bits are unchanged. Its low two bits equal (base + k) mod 4 for beat k, so the burst wraps after four beats.
- R10: With `ilv_mode` = 1, a continued beat k uses low address bits base XOR k.
- R11: `out_en_n` = 1 forces `rd_en` = 0 and `rd_data` = 0 at once, without waiting for a clock edge.
- R12: Continuing after a deselect load stays deselected: nothing is written and the bus stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low starts a new cycle, high continues the burst |
| is_rd | input | 1 | Cycle type at load: 1 read, 0 write |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_we_n | input | NB | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Write data, one active edge after its address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rd_data | output | NB*BW | Read data, zero when not driven |
| rd_en | output | 1 | High when the block drives the read bus |

## Verification
The properties assume that the select, load and type inputs are stable around each rising edge, and that `out_en_n` moves only away from the edges or stays put across a suspended period. The stimulus changes every synchronous input on the falling edge and only pulses the output enable inside a running read cycle. While the clock enable is high the bench holds `out_en_n` steady, so the hold property can compare read data edge to edge. The bench reads back only words it has written, because array contents are undefined after reset.

// File: rtl/lwz_pkg.sv
package lwz_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    localparam int BEAT_BITS = 2;

    // low address bits of a burst beat: linear wraps by adding, interleaved by XOR
    function automatic logic [BEAT_BITS-1:0] beat_lo(
        input logic [BEAT_BITS-1:0] base,
        input logic [BEAT_BITS-1:0] step,
        input logic                 ilv
    );
        beat_lo = ilv ? (base ^ step) : (base + step);
    endfunction

    function automatic logic all_selected(
        input logic s0_n,
        input logic s1,
        input logic s2_n
    );
        all_selected = !s0_n && s1 && !s2_n;
    endfunction

endpackage

// File: rtl/lwz_ctrl.sv
module lwz_ctrl
    import lwz_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en_n,
    input  logic          sel0_n,
    input  logic          sel1,
    input  logic          sel2_n,
    input  logic          load_n,
    input  logic          is_rd,
    input  logic          ilv_mode,
    input  logic [NB-1:0] lane_we_n,
    input  logic [AW-1:0] addr,
    output cyc_e          cyc_q,
    output logic [AW-1:0] addr_q,
    output logic [NB-1:0] be_q
);
    localparam int HI = AW - BEAT_BITS;

    logic [BEAT_BITS-1:0] base_q;
    logic [BEAT_BITS-1:0] step_q;
    logic [BEAT_BITS-1:0] step_nx;
    logic                 adv;
    cyc_e                 load_cyc;

    assign adv     = !clk_en_n;
    assign step_nx = step_q + BEAT_BITS'(1);

    always_comb begin
        if (!all_selected(sel0_n, sel1, sel2_n)) begin
            load_cyc = CYC_IDLE;
        end else if (is_rd) begin
            load_cyc = CYC_READ;
        end else begin
            load_cyc = CYC_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= CYC_IDLE;
            addr_q <= '0;
            be_q   <= '1;
            base_q <= '0;
            step_q <= '0;
        end else if (adv) begin
            be_q <= lane_we_n;
            if (!load_n) begin
                cyc_q  <= load_cyc;
                addr_q <= addr;
                base_q <= addr[BEAT_BITS-1:0];
                step_q <= '0;
            end else begin
                step_q <= step_nx;
                addr_q <= {addr_q[AW-1:BEAT_BITS], beat_lo(base_q, step_nx, ilv_mode)};
            end
        end
    end

    logic [HI-1:0] unused_hi;
    assign unused_hi = addr[AW-1:BEAT_BITS];

endmodule

// File: rtl/lwz_wreg.sv
module lwz_wreg
    import lwz_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en_n,
    input  cyc_e          cyc_q,
    input  logic [AW-1:0] addr_q,
    input  logic [NB-1:0] be_q,
    input  logic [DW-1:0] wdata,
    output logic          reg_v,
    output logic [AW-1:0] reg_addr,
    output logic [NB-1:0] reg_be,
    output logic [DW-1:0] reg_data,
    output logic          commit
);
    localparam int DW = NB * BW;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [NB-1:0] be;
        logic [DW-1:0] d;
    } wslot_t;

    wslot_t slot_q;
    logic   take;

    // data of the write loaded on the previous active edge arrives now
    assign take   = !clk_en_n && (cyc_q == CYC_WRITE);
    // the old entry is flushed to the array only when a newer one replaces it
    assign commit = take && slot_q.v;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (take) begin
            slot_q.v  <= 1'b1;
            slot_q.a  <= addr_q;
            slot_q.be <= be_q;
            slot_q.d  <= wdata;
        end
    end

    assign reg_v    = slot_q.v;
    assign reg_addr = slot_q.a;
    assign reg_be   = slot_q.be;
    assign reg_data = slot_q.d;

endmodule

// File: rtl/lwz_array.sv
module lwz_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NB-1:0] wbe_n,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wbe_n[g]) begin
                store[waddr] <= wdata[g*BW +: BW];
            end
        end

        assign rdata[g*BW +: BW] = store[raddr];
    end

endmodule

// File: rtl/lwz_rdpath.sv
module lwz_rdpath
    import lwz_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  cyc_e          cyc_q,
    input  logic [AW-1:0] addr_q,
    input  logic          out_en_n,
    input  logic [DW-1:0] arr_data,
    input  logic          reg_v,
    input  logic [AW-1:0] reg_addr,
    input  logic [NB-1:0] reg_be,
    input  logic [DW-1:0] reg_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_en
);
    localparam int DW = NB * BW;

    logic          hit;
    logic [DW-1:0] merged;

    assign hit = reg_v && (reg_addr == addr_q);

    for (genvar g = 0; g < NB; g++) begin : g_merge
        assign merged[g*BW +: BW] = (hit && !reg_be[g]) ? reg_data[g*BW +: BW]
                                                        : arr_data[g*BW +: BW];
    end

    assign rd_en   = (cyc_q == CYC_READ) && !out_en_n;
    assign rd_data = rd_en ? merged : '0;

endmodule

// File: rtl/lwz_sram.sv
module lwz_sram
    import lwz_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             load_n,
    input  logic             is_rd,
    input  logic             ilv_mode,
    input  logic [NB-1:0]    lane_we_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    input  logic             out_en_n,
    output logic [NB*BW-1:0] rd_data,
    output logic             rd_en
);
    localparam int DW = NB * BW;

    cyc_e          cyc_q;
    logic [AW-1:0] addr_q;
    logic [NB-1:0] be_q;
    logic          reg_v;
    logic [AW-1:0] reg_addr;
    logic [NB-1:0] reg_be;
    logic [DW-1:0] reg_data;
    logic          commit;
    logic [DW-1:0] arr_data;

    lwz_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .load_n(load_n), .is_rd(is_rd), .ilv_mode(ilv_mode),
        .lane_we_n(lane_we_n), .addr(addr),
        .cyc_q(cyc_q), .addr_q(addr_q), .be_q(be_q)
    );

    lwz_wreg #(.AW(AW), .NB(NB), .BW(BW)) u_wreg (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .cyc_q(cyc_q), .addr_q(addr_q), .be_q(be_q), .wdata(wdata),
        .reg_v(reg_v), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_data(reg_data), .commit(commit)
    );

    lwz_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk(clk), .we(commit), .waddr(reg_addr), .wbe_n(reg_be),
        .wdata(reg_data), .raddr(addr_q), .rdata(arr_data)
    );

    lwz_rdpath #(.AW(AW), .NB(NB), .BW(BW)) u_rdpath (
        .cyc_q(cyc_q), .addr_q(addr_q), .out_en_n(out_en_n),
        .arr_data(arr_data), .reg_v(reg_v), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_data(reg_data),
        .rd_data(rd_data), .rd_en(rd_en)
    );

endmodule

// File: rtl/lwz_sram_chk.sv
module lwz_sram_chk #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en_n,
    input logic             sel0_n,
    input logic             sel1,
    input logic             sel2_n,
    input logic             load_n,
    input logic             is_rd,
    input logic             out_en_n,
    input logic [NB*BW-1:0] rd_data,
    input logic             rd_en
);
    logic sel_ok;
    assign sel_ok = !sel0_n && sel1 && !sel2_n;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !rd_en);

    p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && sel_ok && is_rd && !out_en_n) |=> (rd_en || out_en_n));

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && sel_ok && !is_rd) |=> !rd_en);

    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && !sel_ok) |=> !rd_en);

    p_suspend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(rd_data) || !$stable(out_en_n)));

    p_oe_gate_r11: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!rd_en && rd_data == '0));

endmodule

bind lwz_sram lwz_sram_chk #(.AW(AW), .NB(NB), .BW(BW)) u_chk (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .load_n(load_n), .is_rd(is_rd), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_en(rd_en)
);

// File: tb/lwz_sram_tb.sv
module lwz_sram_tb;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          sel0_n = 1'b1;
    logic          sel1 = 1'b0;
    logic          sel2_n = 1'b1;
    logic          load_n = 1'b0;
    logic          is_rd = 1'b1;
    logic          ilv_mode = 1'b0;
    logic [NB-1:0] lane_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [DW-1:0] mem_ref [1 << AW];
    logic          pend_v  = 1'b0;
    logic [AW-1:0] pend_a  = '0;
    logic [NB-1:0] pend_be = '1;

    always #10 clk = ~clk;

    lwz_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .load_n(load_n), .is_rd(is_rd), .ilv_mode(ilv_mode),
        .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
        .out_en_n(out_en_n), .rd_data(rd_data), .rd_en(rd_en)
    );

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [NB-1:0] ben);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < NB; i++) if (!ben[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
        return r;
    endfunction

    // one clock: inputs set on the falling edge, returns at the next falling edge
    task automatic op(input logic ce_n, input logic s0n, input logic s1, input logic s2n,
                      input logic ldn, input logic rd, input logic [NB-1:0] be,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic mw, input logic [AW-1:0] eff);
        clk_en_n = ce_n; sel0_n = s0n; sel1 = s1; sel2_n = s2n;
        load_n = ldn; is_rd = rd; lane_we_n = be; addr = a; wdata = wd;
        if (!ce_n && pend_v) begin
            mem_ref[pend_a] = lane_merge(mem_ref[pend_a], wd, pend_be);
            pend_v = 1'b0;
        end
        if (!ce_n && mw) begin
            pend_v = 1'b1; pend_a = eff; pend_be = be;
        end
        @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] wd);
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, be, a, wd, 1'b1, a);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, a, wd, 1'b0, a);
    endtask

    task automatic do_idle(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, a, wd, 1'b0, a);
    endtask

    task automatic cont(input logic rd, input logic [NB-1:0] be, input logic [DW-1:0] wd,
                        input logic mw, input logic [AW-1:0] eff);
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, rd, be, 6'h3F, wd, mw, eff);
    endtask

    task automatic chk_rd(input string tag, input logic exp_en, input logic [DW-1:0] exp_d);
        n_chk++;
        if (rd_en !== exp_en || rd_data !== exp_d) begin
            n_bad++;
            $display("FAIL %s: rd_en=%0b rd_data=%h expected rd_en=%0b rd_data=%h",
                     tag, rd_en, rd_data, exp_en, exp_d);
        end
    endtask

    task automatic t_reset();
        chk_rd("R1 reset", 1'b0, '0);
    endtask

    task automatic t_late_write();
        do_write(6'h05, 4'h0, '0);
        chk_rd("R3 write cycle undriven", 1'b0, '0);
        do_read(6'h05, 32'hCAFE_0001);
        chk_rd("R7 read on data edge", 1'b1, 32'hCAFE_0001);
        do_write(6'h06, 4'h0, '0);
        do_idle(6'h00, 32'h0BAD_0006);
        do_write(6'h0A, 4'h0, '0);
        do_idle(6'h00, 32'h1234_000A);
        do_read(6'h05, '0);
        chk_rd("R2 flow-through read", 1'b1, mem_ref[6'h05]);
        do_read(6'h06, '0);
        chk_rd("R3 late data stored", 1'b1, 32'h0BAD_0006);
    endtask

    task automatic t_bytes();
        do_write(6'h08, 4'h0, '0);
        do_idle(6'h00, 32'h1122_3344);
        do_write(6'h08, 4'b1010, '0);
        do_read(6'h08, 32'hAABB_CCDD);
        chk_rd("R7 lane merge bypass", 1'b1, 32'h11BB_33DD);
        do_write(6'h0C, 4'h0, '0);
        do_idle(6'h00, 32'h0000_0C0C);
        do_read(6'h08, '0);
        chk_rd("R4 lanes from array", 1'b1, 32'h11BB_33DD);
        do_write(6'h08, 4'b0111, '0);
        do_idle(6'h00, 32'hEE00_0000);
        do_read(6'h08, '0);
        chk_rd("R4 top lane only", 1'b1, 32'hEEBB_33DD);
    endtask

    task automatic t_select();
        do_write(6'h09, 4'h0, '0);
        do_idle(6'h00, 32'h9999_9999);
        for (int k = 0; k < 3; k++) begin
            op(1'b0, k == 0, k != 1, k == 2, 1'b0, 1'b0, 4'h0, 6'h09, '0, 1'b0, 6'h09);
            chk_rd("R5 deselected write", 1'b0, '0);
            op(1'b0, k == 0, k != 1, k == 2, 1'b0, 1'b1, '1, 6'h09, 32'h5555_5555, 1'b0, 6'h09);
            chk_rd("R5 deselected read", 1'b0, '0);
            do_read(6'h09, '0);
            chk_rd("R5 word untouched", 1'b1, 32'h9999_9999);
        end
    endtask

    task automatic t_pingpong();
        for (int i = 0; i < 6; i++) begin
            do_write(6'h10 + 6'(i), 4'h0, '0);
            do_read(6'h10 + 6'(i), 32'hA5A5_0000 + 32'(i));
            chk_rd("R6 read after write", 1'b1, 32'hA5A5_0000 + 32'(i));
        end
        for (int i = 0; i < 6; i++) begin
            do_read(6'h10 + 6'(i), '0);
            chk_rd("R6 back-to-back reads", 1'b1, 32'hA5A5_0000 + 32'(i));
        end
    endtask

    task automatic t_oe();
        out_en_n = 1'b1;
        do_read(6'h10, '0);
        chk_rd("R11 oe high", 1'b0, '0);
        out_en_n = 1'b0;
        #1;
        chk_rd("R11 oe low mid-cycle", 1'b1, mem_ref[6'h10]);
        out_en_n = 1'b1;
        #1;
        chk_rd("R11 oe high mid-cycle", 1'b0, '0);
        out_en_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_suspend();
        do_read(6'h11, '0);
        chk_rd("R8 read before hold", 1'b1, mem_ref[6'h11]);
        for (int i = 0; i < 2; i++) begin
            op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'h11, 32'hDEAD_DEAD, 1'b1, 6'h11);
            chk_rd("R8 output held", 1'b1, 32'hA5A5_0001);
        end
        do_write(6'h30, 4'h0, '0);
        op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'h11, 32'hDEAD_BEEF, 1'b0, 6'h11);
        do_read(6'h30, 32'h3030_3030);
        chk_rd("R8 data after suspend", 1'b1, 32'h3030_3030);
        do_read(6'h11, '0);
        chk_rd("R8 no write while held", 1'b1, 32'hA5A5_0001);
    endtask

    task automatic t_burst();
        ilv_mode = 1'b0;
        do_write(6'h21, 4'h0, '0);
        cont(1'b1, 4'h0, 32'hB000_0021, 1'b1, 6'h22);
        cont(1'b1, 4'h0, 32'hB000_0022, 1'b1, 6'h23);
        cont(1'b1, 4'h0, 32'hB000_0023, 1'b1, 6'h20);
        do_idle(6'h00, 32'hB000_0020);
        for (int i = 0; i < 4; i++) begin
            do_read(6'h20 + 6'(i), '0);
            chk_rd("R9 linear write beats", 1'b1, 32'hB000_0020 + 32'(i));
        end
        do_read(6'h22, '0);
        chk_rd("R9 linear beat 0", 1'b1, 32'hB000_0022);
        cont(1'b1, '1, '0, 1'b0, 6'h23);
        chk_rd("R9 linear beat 1", 1'b1, 32'hB000_0023);
        cont(1'b1, '1, '0, 1'b0, 6'h20);
        chk_rd("R9 linear beat 2", 1'b1, 32'hB000_0020);
        cont(1'b1, '1, '0, 1'b0, 6'h21);
        chk_rd("R9 linear beat 3", 1'b1, 32'hB000_0021);
        cont(1'b1, '1, '0, 1'b0, 6'h22);
        chk_rd("R9 linear wrap", 1'b1, 32'hB000_0022);
        ilv_mode = 1'b1;
        do_read(6'h21, '0);
        chk_rd("R10 interleaved beat 0", 1'b1, 32'hB000_0021);
        cont(1'b1, '1, '0, 1'b0, 6'h20);
        chk_rd("R10 interleaved beat 1", 1'b1, 32'hB000_0020);
        cont(1'b1, '1, '0, 1'b0, 6'h23);
        chk_rd("R10 interleaved beat 2", 1'b1, 32'hB000_0023);
        cont(1'b1, '1, '0, 1'b0, 6'h22);
        chk_rd("R10 interleaved beat 3", 1'b1, 32'hB000_0022);
        ilv_mode = 1'b0;
    endtask

    task automatic t_desel_cont();
        do_idle(6'h21, '0);
        cont(1'b0, 4'h0, '0, 1'b0, 6'h22);
        chk_rd("R12 continue stays idle", 1'b0, '0);
        cont(1'b1, '1, 32'h7777_7777, 1'b0, 6'h23);
        chk_rd("R12 continue read idle", 1'b0, '0);
        do_idle(6'h00, 32'h7777_7777);
        do_read(6'h22, '0);
        chk_rd("R12 word untouched", 1'b1, 32'hB000_0022);
        do_read(6'h23, '0);
        chk_rd("R12 next word untouched", 1'b1, 32'hB000_0023);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_late_write();
        t_bytes();
        t_select();
        t_pingpong();
        t_oe();
        t_suspend();
        t_burst();
        t_desel_cont();
        do_idle(6'h00, '0);
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule